// File: doc/BRIEF.md
# Prime-Modulus Bank Address Mapper

This block turns a linear word address into a location in an interleaved memory. The memory has a prime number of banks, `NB = 2^M - 1`, and a power-of-two number of words in each bank, `NW = 2^OFF_W`. The bank number is the address modulo `NB`. The word offset inside that bank is the address modulo `NW`. `NB` is odd and `NW` is a power of two, so the two moduli share no factor. As a result, every run of `NB*NW` consecutive addresses lands on distinct (bank, offset) pairs. Strides that are powers of two spread across all the banks instead of piling onto one.

The block uses no divider to form the bank number. The address is cut into `M`-bit slices. Because `2^k mod NB = 2^(k mod M)`, each slice already holds the residue of its own bits, so the slices are summed directly. The sum is then folded back into `M` bits with end-around carry. If the folded value equals `NB`, it is mapped to zero. The offset is simply the low address bits.

Addresses enter with a valid strobe, one per cycle and with no back-pressure. They leave in order after a fixed number of register stages, `LATENCY`, which may be 1 or 2.

Top module: `prime_bank_mapper`

## Requirements
- R1: For every accepted address A, `out_bank` equals A mod (2^M - 1). With the defaults this is A mod 7.
- R2: For every accepted address A, `out_offset` equals A mod 2^OFF_W, which is address bits [OFF_W-1:0].
- R3: When `out_valid` is high, `out_bank` is never 2^M - 1 (all ones). An address that is a nonzero multiple of NB, such as 7 or 14, produces bank 0.
- R4: `out_valid` is high exactly LATENCY cycles after a cycle in which `in_valid` was high, and is low otherwise. `in_addr` is ignored in cycles where `in_valid` is low.
- R5: One address is accepted every cycle with no gaps between results. Results leave in the order their addresses arrived.
- R6: While `rst_n` is low, `out_valid`, `out_bank` and `out_offset` are all 0. Any address in flight when reset is asserted is discarded.
- R7: The addresses 0 to NB*NW-1 map onto NB*NW distinct (bank, offset) pairs, which together cover every pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Address strobe |
| in_addr | input | ADDR_W | Linear word address |
| out_valid | output | 1 | Result strobe, LATENCY cycles after `in_valid` |
| out_bank | output | M | Bank number, address mod (2^M - 1) |
| out_offset | output | OFF_W | Word offset within the bank |

## Verification
The properties assume three things about the inputs:
- `in_addr` matters only in cycles where `in_valid` is high.
- `LATENCY` is 1 or 2.
- Checks that look back LATENCY cycles are meaningful only once that many edges have passed since reset. A small counter in the checker enforces this.

The stimulus respects these assumptions. It changes inputs only on the falling clock edge and holds `in_valid` low for as long as reset is asserted. In idle cycles it drives changing, unrelated addresses, so the "ignored when not valid" rule is actually exercised.

// File: rtl/pbm_pkg.sv
package pbm_pkg;

    // number of M-bit slices needed to cover the address
    function automatic int chunk_count(input int addr_w, input int m);
        return (addr_w + m - 1) / m;
    endfunction

    // width that holds the sum of all slices without overflow
    function automatic int sum_width(input int addr_w, input int m);
        return m + $clog2(chunk_count(addr_w, m));
    endfunction

    // end-around folds needed to bring a sum back to M bits
    function automatic int fold_count(input int sum_w, input int m);
        return (sum_w + m - 1) / m + 1;
    endfunction

endpackage

// File: rtl/pbm_chunk_sum.sv
module pbm_chunk_sum #(
    parameter int ADDR_W = 16,
    parameter int M      = 3,
    parameter int NCHUNK = 6,
    parameter int SUM_W  = 6
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [SUM_W-1:0]  sum
);
    localparam int PAD_W = NCHUNK * M;

    logic [PAD_W-1:0] padded;
    logic [SUM_W-1:0] acc [NCHUNK+1];

    assign padded = PAD_W'(addr);
    assign acc[0] = '0;

    // each slice already equals the residue of its bits, since 2^k mod NB = 2^(k mod M)
    for (genvar g = 0; g < NCHUNK; g++) begin : g_slice
        assign acc[g+1] = acc[g] + SUM_W'(padded[g*M +: M]);
    end

    assign sum = acc[NCHUNK];
endmodule

// File: rtl/pbm_fold.sv
module pbm_fold #(
    parameter int SUM_W = 6,
    parameter int M     = 3,
    parameter int NFOLD = 3
) (
    input  logic [SUM_W-1:0] sum,
    output logic [M-1:0]     bank
);
    localparam logic [M-1:0] NB_CODE = '1;

    logic [SUM_W-1:0] step [NFOLD+1];
    logic [M-1:0]     folded;

    assign step[0] = sum;

    // add the bits above M back into the low M bits (end-around carry)
    for (genvar f = 0; f < NFOLD; f++) begin : g_fold
        assign step[f+1] = SUM_W'(step[f][M-1:0]) + (step[f] >> M);
    end

    assign folded = step[NFOLD][M-1:0];
    // the all-ones code is congruent to zero
    assign bank   = (folded == NB_CODE) ? '0 : folded;
endmodule

// File: rtl/prime_bank_mapper.sv
module prime_bank_mapper
    import pbm_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int M       = 3,
    parameter int OFF_W   = 4,
    parameter int LATENCY = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] in_addr,
    output logic              out_valid,
    output logic [M-1:0]      out_bank,
    output logic [OFF_W-1:0]  out_offset
);
    localparam int NCHUNK = chunk_count(ADDR_W, M);
    localparam int SUM_W  = sum_width(ADDR_W, M);
    localparam int NFOLD  = fold_count(SUM_W, M);

    typedef struct packed {
        logic             s1_vld;
        logic [SUM_W-1:0] s1_sum;
        logic [OFF_W-1:0] s1_off;
        logic             o_vld;
        logic [M-1:0]     o_bank;
        logic [OFF_W-1:0] o_off;
    } pipe_t;

    pipe_t st_d, st_q;

    logic [SUM_W-1:0] sum_now;
    logic [SUM_W-1:0] fold_src;
    logic [M-1:0]     bank_now;
    logic             src_vld;
    logic [OFF_W-1:0] src_off;

    pbm_chunk_sum #(
        .ADDR_W(ADDR_W), .M(M), .NCHUNK(NCHUNK), .SUM_W(SUM_W)
    ) u_chunk_sum (
        .addr (in_addr),
        .sum  (sum_now)
    );

    // LATENCY picks where the fold sits: after a sum register or straight after the adders
    if (LATENCY == 2) begin : g_two_stage
        assign fold_src = st_q.s1_sum;
        assign src_vld  = st_q.s1_vld;
        assign src_off  = st_q.s1_off;
    end else begin : g_one_stage
        assign fold_src = sum_now;
        assign src_vld  = in_valid;
        assign src_off  = in_addr[OFF_W-1:0];
    end

    pbm_fold #(
        .SUM_W(SUM_W), .M(M), .NFOLD(NFOLD)
    ) u_fold (
        .sum  (fold_src),
        .bank (bank_now)
    );

    always_comb begin
        st_d        = st_q;
        st_d.s1_vld = in_valid;
        if (in_valid) begin
            st_d.s1_sum = sum_now;
            st_d.s1_off = in_addr[OFF_W-1:0];
        end
        st_d.o_vld = src_vld;
        if (src_vld) begin
            st_d.o_bank = bank_now;
            st_d.o_off  = src_off;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid  = st_q.o_vld;
    assign out_bank   = st_q.o_bank;
    assign out_offset = st_q.o_off;
endmodule

// File: rtl/pbm_checker.sv
module pbm_checker #(
    parameter int ADDR_W  = 16,
    parameter int M       = 3,
    parameter int OFF_W   = 4,
    parameter int LATENCY = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [ADDR_W-1:0] in_addr,
    input logic              out_valid,
    input logic [M-1:0]      out_bank,
    input logic [OFF_W-1:0]  out_offset
);
    localparam logic [ADDR_W-1:0] NB_A    = ADDR_W'((1 << M) - 1);
    localparam logic [M-1:0]      NB_CODE = '1;

    logic [1:0] warm;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            warm <= '0;
        end else if (warm != 2'd3) begin
            warm <= warm + 2'd1;
        end
    end

    assert_bank_residue_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(warm) >= LATENCY && $past(in_valid, LATENCY))
        |-> (out_bank == M'($past(in_addr, LATENCY) % NB_A)));

    assert_offset_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(warm) >= LATENCY && $past(in_valid, LATENCY))
        |-> (out_offset == $past(in_addr[OFF_W-1:0], LATENCY)));

    assert_bank_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_bank != NB_CODE));

    assert_valid_delay_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(warm) >= LATENCY) |-> (out_valid == $past(in_valid, LATENCY)));

    assert_reset_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!out_valid && out_bank == '0 && out_offset == '0));
endmodule

bind prime_bank_mapper pbm_checker #(
    .ADDR_W(ADDR_W), .M(M), .OFF_W(OFF_W), .LATENCY(LATENCY)
) u_pbm_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_addr    (in_addr),
    .out_valid  (out_valid),
    .out_bank   (out_bank),
    .out_offset (out_offset)
);

// File: tb/prime_bank_mapper_bench.sv
`timescale 1ns/1ps
module prime_bank_mapper_bench;
    localparam int ADDR_W  = 16;
    localparam int M       = 3;
    localparam int OFF_W   = 4;
    localparam int LATENCY = 2;
    localparam int NB      = (1 << M) - 1;
    localparam int NW      = 1 << OFF_W;
    localparam int SPAN    = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic [ADDR_W-1:0] in_addr = '0;
    logic              out_valid;
    logic [M-1:0]      out_bank;
    logic [OFF_W-1:0]  out_offset;

    always #10 clk = ~clk;

    prime_bank_mapper #(
        .ADDR_W(ADDR_W), .M(M), .OFF_W(OFF_W), .LATENCY(LATENCY)
    ) u_prime_bank_mapper (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr(in_addr),
        .out_valid(out_valid), .out_bank(out_bank), .out_offset(out_offset)
    );

    typedef struct {
        int     addr;
        int     bank;
        int     off;
        longint stamp;
    } exp_t;

    exp_t   sb[$];
    int     checks = 0;
    int     errors = 0;
    longint cyc = 0;
    bit     uniq_on = 1'b0;
    bit     seen [NB][NW];
    int     seen_cnt = 0;

    always @(posedge clk) cyc++;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic drive(input int a);
        exp_t e;
        @(negedge clk);
        in_valid = 1'b1;
        in_addr  = ADDR_W'(a);
        e.addr = a; e.bank = a % NB; e.off = a % NW; e.stamp = cyc;
        sb.push_back(e);
    endtask

    task automatic idle(input int junk);
        @(negedge clk);
        in_valid = 1'b0;
        in_addr  = ADDR_W'(junk);
    endtask

    task automatic drain();
        for (int i = 0; i < 50 && sb.size() != 0; i++) idle(i * 37);
        check(sb.size() == 0, "R5 results outstanding after drain", sb.size(), 0);
    endtask

    // monitor: compares each result against the oldest expected item
    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R4 unexpected out_valid", 1, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(int'(out_bank) == e.bank, "R1 bank", out_bank, e.bank);
                    check(int'(out_offset) == e.off, "R2 offset", out_offset, e.off);
                    check(int'(out_bank) < NB, "R3 bank range", out_bank, NB - 1);
                    check(cyc - e.stamp == LATENCY, "R5 order/latency", cyc - e.stamp, LATENCY);
                    if (uniq_on && e.addr < NB * NW && int'(out_bank) < NB) begin
                        check(!seen[out_bank][out_offset], "R7 duplicate pair", e.addr, -1);
                        if (!seen[out_bank][out_offset]) seen_cnt++;
                        seen[out_bank][out_offset] = 1'b1;
                    end
                end
            end else if (sb.size() != 0) begin
                check(cyc - sb[0].stamp < LATENCY, "R4 missing out_valid", cyc - sb[0].stamp, LATENCY - 1);
            end
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R5 watchdog: cycles %0d expected below %0d", cyc, 190000);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        // R6: outputs clear under reset
        repeat (3) begin
            @(negedge clk);
            check(out_valid == 1'b0, "R6 reset out_valid", out_valid, 0);
            check(out_bank == '0 && out_offset == '0, "R6 reset data", {out_bank, out_offset}, 0);
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R1 R2 R3 R5 R7: every address, back to back
        uniq_on = 1'b1;
        for (int a = 0; a < SPAN; a++) drive(a);
        drain();
        uniq_on = 1'b0;
        check(seen_cnt == NB * NW, "R7 pair coverage", seen_cnt, NB * NW);

        // R3: multiples of NB and the all-ones address
        drive(NB); drive(2 * NB); drive(NB * NW); drive(SPAN - 1); drive(SPAN - 2);
        drain();

        // R4: valid strobes with idle gaps carrying garbage addresses
        lfsr = 16'hACE1;
        for (int i = 0; i < 3000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (lfsr[0] && lfsr[3]) idle(int'(lfsr));
            else drive(int'(lfsr) % SPAN);
        end
        drain();

        // R6: reset while results are in flight discards them
        drive(100); drive(200);
        @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b0;
        sb.delete();
        @(negedge clk);
        check(out_valid == 1'b0, "R6 flush out_valid", out_valid, 0);
        check(out_bank == '0 && out_offset == '0, "R6 flush data", {out_bank, out_offset}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (4) idle(55);
        drive(12345); drive(0); drive(NB - 1);
        drain();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule